// File: doc/BRIEF.md
# IrDA Low-Power Pulse Timing Generator

This block turns a fast peripheral clock into a slow, evenly spaced strobe, the low-power baud16 tick. An 8-bit divisor held in a small bus register sets the strobe's rate. The tick rate is the clock rate divided by the divisor. The divisor is normally chosen so that the tick runs near 1.8432 MHz. A divisor of zero is not a legal setting, and while it is held the strobe stops completely.

The same strobe sets the width of low-power infrared transmit pulses. A one-cycle request arms the pulse generator. At the next tick the infrared output goes high, and it stays high for exactly three tick periods. Over the allowed tick range this gives a pulse of roughly 1.41 to 2.11 µs. While a pulse is armed or running, further requests are ignored. When the divisor is zero, the generator refuses requests and cuts short any pulse in progress, so the output cannot stay high.

Top module: `irlp_pulse_timer`

## Requirements
- R1: The divisor is an 8-bit register, written from `reg_wdata[7:0]` when `reg_wr` is high at a clock edge and returned on `reg_rdata[7:0]`. It reads 0 after reset and keeps its value in every cycle without a write.
- R2: Bits 31:8 of `reg_rdata` always read 0, and bits 31:8 of `reg_wdata` have no effect on anything.
- R3: With a nonzero divisor D, `lp_tick` is high for one clock cycle every D cycles (every cycle when D is 1). After D is written over a zero divisor at edge k, the first tick is high in the cycle that follows edge k+D.
- R4: While the divisor is zero, `lp_tick` stays low, starting in the cycle right after the write of zero.
- R5: A new nonzero divisor written while counting does not shorten or stretch the current tick period. It sets the spacing from the next tick onward.
- R6: An accepted request raises `ir_out` in the cycle after the first tick that follows the request. `ir_out` stays high for exactly 3·D cycles, ending after the third further tick.
- R7: A request that arrives while a pulse is armed or active is ignored and does not lengthen the pulse or start a new one.
- R8: A request made while the divisor is zero is dropped, and `ir_out` stays low.
- R9: If the divisor becomes zero while a pulse is armed or active, the pulse is aborted and `ir_out` is low from the second cycle after the write onward.
- R10: A synchronous reset (`rst_n` low at a clock edge) clears the divisor, the tick counter, any pulse in progress and `ir_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Divisor register write strobe |
| reg_wdata | input | 32 | Register write word; only bits 7:0 are used |
| reg_rdata | output | 32 | Register read word: zero-extended divisor |
| pulse_req | input | 1 | Request for one low-power infrared pulse |
| lp_tick | output | 1 | One-cycle low-power baud16 tick |
| ir_out | output | 1 | Infrared transmit output, high during a pulse |

## Verification
On every cycle, the embedded assertions check four things: the divisor holds between writes, a tick is never followed by another tick unless the divisor is one, the counter empties under a zero divisor, and `ir_out` rises only right after a tick and drops once the divisor is zero. Only the bench's scenarios can show quantities that build up over many cycles: the exact tick spacing, the 3·D pulse width, the reload-time effect of a mid-count divisor change, that requests made while busy or while the divisor is zero are ignored, and the return to a clean state after reset. The bench checks these against a cycle-level reference model and against directed measurements.

// File: rtl/irlp_pkg.sv
// Shared constants and types for the low-power infrared pulse timer.
// Assumes one clock domain; all widths derive from these defaults.
package irlp_pkg;
    localparam int unsigned DIV_W       = 8;   // divisor register width
    localparam int unsigned BUS_W       = 32;  // register bus word width
    localparam int unsigned PULSE_TICKS = 3;   // tick periods per IR pulse

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_ARMED  = 2'd1,
        PS_ACTIVE = 2'd2
    } pulse_state_e;
endpackage

// File: rtl/irlp_divreg.sv
// Divisor register: stores the low byte of each bus write and returns
// it zero-extended on the read word. Assumes a single register, so no
// address decode is needed.
module irlp_divreg #(
    parameter int unsigned DIV_W = irlp_pkg::DIV_W,
    parameter int unsigned BUS_W = irlp_pkg::BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic [DIV_W-1:0] div_o
);
    localparam int unsigned PAD_W = BUS_W - DIV_W;

    logic [DIV_W-1:0] div_q;

    // Capture the divisor byte on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (wr_i) div_q <= wdata_i[DIV_W-1:0];
    end

    // Form the read word with the reserved bits tied low.
    always_comb begin
        rdata_o = {{PAD_W{1'b0}}, div_q};
    end

    assign div_o = div_q;

    // R1: the divisor changes only through a write.
    assert_hold_without_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(div_q));
endmodule

// File: rtl/irlp_tick_gen.sv
// Tick generator: a down-counter that loads the divisor, fires a
// one-cycle tick when it reaches one, then reloads. A zero divisor
// empties the counter and holds the tick low. A new divisor is picked up
// only at reload, so the period in progress is never cut or stretched.
module irlp_tick_gen #(
    parameter int unsigned DIV_W = irlp_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic             div_zero;

    assign div_zero = (div_i == '0);

    // Count down, reloading from the divisor at one or from empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (div_zero)                  cnt_q <= '0;
        else if (cnt_q == '0 || cnt_q == ONE) cnt_q <= div_i;
        else                                cnt_q <= cnt_q - ONE;
    end

    // Tick while the counter sits at one under a legal divisor.
    always_comb begin
        tick_o = (cnt_q == ONE) && !div_zero;
    end

    // R3: one cycle wide unless the divisor is one.
    assert_single_cycle_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != ONE) |=> !tick_o);
    // R4: a zero divisor empties the counter by the next cycle.
    assert_zero_div_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |=> (cnt_q == '0));
endmodule

// File: rtl/irlp_pulse_fsm.sv
// Pulse sequencer: accepts a request when idle and the divisor is legal,
// waits for the next tick, then holds the IR output high across the
// following PULSE_TICKS tick periods. Assumes tick_i is one cycle wide.
// A zero divisor aborts any pulse so the output never sticks high.
module irlp_pulse_fsm
    import irlp_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = irlp_pkg::PULSE_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic tick_i,
    input  logic div_zero_i,
    output logic ir_o
);
    localparam int unsigned TCW = $clog2(PULSE_TICKS + 1);
    localparam logic [TCW-1:0] LAST = TCW'(PULSE_TICKS - 1);

    pulse_state_e   state_q;
    logic [TCW-1:0] ticks_q;
    logic           ir_q;

    // Sequence idle -> armed -> active -> idle on ticks; abort on zero divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            ticks_q <= '0;
            ir_q    <= 1'b0;
        end else if (div_zero_i) begin
            state_q <= PS_IDLE;
            ticks_q <= '0;
            ir_q    <= 1'b0;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    if (req_i) state_q <= PS_ARMED;
                end
                PS_ARMED: begin
                    if (tick_i) begin
                        state_q <= PS_ACTIVE;
                        ticks_q <= '0;
                        ir_q    <= 1'b1;
                    end
                end
                PS_ACTIVE: begin
                    if (tick_i) begin
                        if (ticks_q == LAST) begin
                            state_q <= PS_IDLE;
                            ir_q    <= 1'b0;
                        end else begin
                            ticks_q <= ticks_q + TCW'(1);
                        end
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    assign ir_o = ir_q;

    // R6: the output rises only in the cycle after a tick.
    assert_rise_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_q) |-> $past(tick_i));
    // R9: a zero divisor drops a high output by the next cycle.
    assert_abort_on_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q && div_zero_i) |=> !ir_q);
endmodule

// File: rtl/irlp_pulse_timer.sv
// Top level: divisor register, tick generator and pulse sequencer.
// Assumes a single peripheral clock and a synchronous active-low reset.
module irlp_pulse_timer
    import irlp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             pulse_req,
    output logic             lp_tick,
    output logic             ir_out
);
    logic [DIV_W-1:0] div_val;
    logic             div_zero;

    assign div_zero = (div_val == '0);

    irlp_divreg #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_divreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .div_o   (div_val)
    );

    irlp_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_val),
        .tick_o (lp_tick)
    );

    irlp_pulse_fsm #(.PULSE_TICKS(PULSE_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (pulse_req),
        .tick_i     (lp_tick),
        .div_zero_i (div_zero),
        .ir_o       (ir_out)
    );

    // R10: the cycle after a reset edge shows a quiet, cleared block.
    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (!ir_out && !lp_tick && reg_rdata == '0));
endmodule

// File: tb/irlp_pulse_timer_tb.sv
// Bench: a behavioural reference model is compared with the outputs on
// every cycle, plus directed measurements of tick spacing and pulse width.
module irlp_pulse_timer_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  MAX_CYCLES = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pulse_req = 1'b0;
    logic        lp_tick;
    logic        ir_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_div = 0, m_rem = 0, m_phase = 0, m_seen = 0;
    bit m_ir = 1'b0;

    irlp_pulse_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pulse_req(pulse_req), .lp_tick(lp_tick), .ir_out(ir_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model, advanced once per rising edge.
    always @(posedge clk) begin
        bit tk;
        cycles++;
        if (!rst_n) begin
            m_div = 0; m_rem = 0; m_phase = 0; m_seen = 0; m_ir = 0;
            model_on = 1'b1;
        end else begin
            tk = (m_rem == 1) && (m_div != 0);
            if (m_div == 0) begin
                m_phase = 0; m_ir = 0;          // R8, R9
            end else if (m_phase == 0) begin
                if (pulse_req) m_phase = 1;
            end else if (m_phase == 1) begin
                if (tk) begin m_phase = 2; m_seen = 0; m_ir = 1; end
            end else if (tk) begin
                if (m_seen == 2) begin m_phase = 0; m_ir = 0; end
                else m_seen++;
            end
            if (m_div == 0)      m_rem = 0;
            else if (m_rem <= 1) m_rem = m_div;   // R5: new divisor at reload
            else                 m_rem--;
            if (reg_wr) m_div = reg_wdata & 32'hFF; // R1, R2
        end
    end

    // Cycle-by-cycle comparison away from the clock edge.
    always @(negedge clk) begin
        if (model_on && !done) begin
            check(lp_tick == ((m_rem == 1) && (m_div != 0)), "R3/R4/R5", "lp_tick",
                  lp_tick, (m_rem == 1) && (m_div != 0));
            check(ir_out == m_ir, "R6/R7/R8/R9", "ir_out", ir_out, m_ir);
            check(reg_rdata == 32'(m_div), "R1/R2", "reg_rdata", reg_rdata, m_div);
        end
        if (cycles > MAX_CYCLES && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, MAX_CYCLES);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_div(input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic request();
        @(negedge clk); pulse_req = 1'b1;
        @(negedge clk); pulse_req = 1'b0;
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 600 && !lp_tick; i++) @(negedge clk);
    endtask

    // R3: spacing between two consecutive ticks.
    task automatic measure_period(input int exp);
        int n;
        wait_tick();
        n = 0;
        do begin @(negedge clk); n++; end while (!lp_tick && n < 600);
        check(n == exp, "R3", "tick period", n, exp);
    endtask

    // R6: high time of the next pulse; raises a busy request midway (R7).
    task automatic measure_pulse(input int exp);
        int n;
        for (int i = 0; i < 2000 && !ir_out; i++) @(negedge clk);
        n = 0;
        while (ir_out && n < 2000) begin
            pulse_req = (n == 1);
            @(negedge clk); n++;
        end
        pulse_req = 1'b0;
        check(n == exp, "R6", "pulse width", n, exp);
    endtask

    initial begin
        int hi;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(reg_rdata == 0 && !lp_tick && !ir_out, "R10", "reset state",
              reg_rdata, 0);

        // R1, R2: reserved bits dropped on write, zero on read
        write_div(32'hFFFF_FF05);
        check(reg_rdata == 32'h5, "R2", "read word", reg_rdata, 5);
        check(reg_rdata[7:0] == 8'h5, "R1", "divisor byte", reg_rdata[7:0], 5);

        measure_period(5);
        measure_period(5);

        // R6 and R7: pulse of 3 periods; request while armed is ignored
        @(negedge clk); pulse_req = 1'b1;
        step(2); pulse_req = 1'b0;
        measure_pulse(15);
        hi = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); hi += ir_out; end
        check(hi == 0, "R7", "no extra pulse after busy requests", hi, 0);

        // R5: divisor change mid-count
        wait_tick();
        step(2);
        write_div(32'h3);
        measure_period(3);

        // D = 1: tick every cycle, pulse 3 cycles
        write_div(32'h1);
        measure_period(1);
        request();
        measure_pulse(3);

        // R4: zero divisor stops ticks
        write_div(32'h0);
        hi = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); hi += lp_tick; end
        check(hi == 0, "R4", "ticks under zero divisor", hi, 0);

        // R8: request under zero divisor dropped, even after divisor returns
        request();
        step(5);
        write_div(32'h2);
        hi = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); hi += ir_out; end
        check(hi == 0, "R8", "ir after dropped request", hi, 0);

        // R9: zero divisor aborts a running pulse
        write_div(32'h4);
        request();
        for (int i = 0; i < 200 && !ir_out; i++) @(negedge clk);
        step(2);
        write_div(32'h0);
        @(negedge clk);
        check(!ir_out, "R9", "ir after abort", ir_out, 0);

        // R10: reset during a pulse
        write_div(32'h6);
        request();
        for (int i = 0; i < 200 && !ir_out; i++) @(negedge clk);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        check(!ir_out && !lp_tick && reg_rdata == 0, "R10", "state after reset",
              {ir_out, lp_tick} , 0);
        step(10);
        check(!ir_out && !lp_tick, "R10", "quiet after reset", {ir_out, lp_tick}, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule